// File: doc/BRIEF.md
# Controller Command Packet Responder

This block sits behind a host transfer engine. It takes a finished host packet as a byte stream and reads the type byte and, for controller packets, the command byte. It then writes a reply packet into the engine's inbound buffer through an addressed byte write port. When the reply is complete it raises a one-cycle done strobe that carries the reply length.

Controller commands cover several jobs:
- Autopoll on/off.
- Time queries, answered from a seconds counter whose epoch is the start of 1904.
- A group of settings that are only acknowledged.
- A power-down request, which also emits a shutdown pulse.

Peripheral-bus packets are handed, without their type byte, to an external bus model over a simple request/response port. While autopoll is on, a fixed-period timer asks the same port for unsolicited poll data. Any data it returns is sent up as its own reply packet.

Reply bytes land at buffer addresses 0 upward. Header bytes are written after any bus data, so payload bytes from the bus go straight to address 2 and up.

Top module: `cmd_responder`

## Requirements
- R1: After reset the block issues no writes, no done strobe, no shutdown pulse, no poll and no bus request, and autopoll is off (`poll_on` = 0).
- R2: Controller packet type 1 with command 0x01 sets `poll_on` to (argument byte != 0) and replies {0x01, argument}. A missing argument byte counts as 0x00.
- R3: While `poll_on` is 1, `bus_poll` pulses for one cycle every POLL_DIV cycles, counted from the cycle autopoll was enabled. A successful poll reply of bytes d0..dn is sent as {0x00, 0x40, d0..dn}. A failed poll sends nothing. With `poll_on` at 0, no poll is issued.
- R4: Commands 0x03 and 0x09 both reply with seven bytes {0x01, 0x00, 0x00, s[31:24], s[23:16], s[15:8], s[7:0]}, where s is the seconds value.
- R5: The seconds value resets to SEC_INIT and increments by one on each cycle with `sec_tick` high. SEC_INIT defaults to the count of seconds from 1904-01-01 to 1970-01-01, 2082844800.
- R6: Commands 0x13, 0x14, 0x19 and 0x21 reply {0x01, 0x00}.
- R7: Command 0x0A replies {0x01, 0x00}. It also raises `shutdown_req` for exactly one cycle, in the cycle after the packet's last byte is accepted.
- R8: For a type 0 packet, every byte after the type byte goes out on `bus_req_*`, and the final byte is marked with `bus_req_last`. A successful response d0..dn gives reply {0x00, 0x00, d0..dn}. An error beat (`bus_rsp_err`) carrying code c gives reply {0x00, c}.
- R9: Packets of type 2 and above, one-byte packets, and controller packets with any command not listed above produce no reply.
- R10: Input bytes that arrive while a reply is pending are ignored, from the acceptance of a packet's last byte until its done strobe.
- R11: `out_done` is high only together with a write, and `out_len` equals the number of bytes written for that reply. Bus data beyond 2^RSP_AW - 2 bytes is dropped, so the length saturates at 2^RSP_AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host packet byte valid |
| in_data | input | 8 | Host packet byte |
| in_last | input | 1 | Marks the final byte of a host packet |
| sec_tick | input | 1 | One-cycle strobe once per second |
| bus_req_valid | output | 1 | Forwarded bus request byte valid |
| bus_req_data | output | 8 | Forwarded bus request byte |
| bus_req_last | output | 1 | Final forwarded request byte |
| bus_poll | output | 1 | One-cycle autopoll request to the bus model |
| bus_rsp_valid | input | 1 | Bus response beat valid |
| bus_rsp_data | input | 8 | Bus response data byte, or error code on an error beat |
| bus_rsp_last | input | 1 | Final bus response beat |
| bus_rsp_err | input | 1 | Error beat (single, final) |
| out_we | output | 1 | Reply buffer write enable |
| out_addr | output | RSP_AW | Reply buffer byte address |
| out_data | output | 8 | Reply buffer byte |
| out_done | output | 1 | Reply complete strobe |
| out_len | output | RSP_AW+1 | Reply length in bytes, valid with out_done |
| poll_on | output | 1 | Autopoll enable flag |
| shutdown_req | output | 1 | One-cycle shutdown request |

## Verification
Every command in the fixed set is sent, so that reply formats cannot be confused with one another. These include the two time commands, before and after seconds ticks, which separates reset value from counting. Peripheral-bus traffic is tried with a successful multi-byte response, an error beat, and a response longer than the buffer, which tells payload placement apart from header content and saturation. Unknown types, unknown commands and a one-byte packet check for silence. Packets injected while a bus reply is pending show that busy input is dropped. Autopoll is tried with a missing argument, with a non-zero argument, and with disable, and polls are answered both with data and with an error; the spacing between two polls is measured.

// File: rtl/cmd_responder.sv
module cmd_responder #(
  parameter int          RSP_AW   = 7,
  parameter int          POLL_DIV = 2_000_000,
  parameter logic [31:0] SEC_INIT = 32'd2082844800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              sec_tick,
  output logic              bus_req_valid,
  output logic [7:0]        bus_req_data,
  output logic              bus_req_last,
  output logic              bus_poll,
  input  logic              bus_rsp_valid,
  input  logic [7:0]        bus_rsp_data,
  input  logic              bus_rsp_last,
  input  logic              bus_rsp_err,
  output logic              out_we,
  output logic [RSP_AW-1:0] out_addr,
  output logic [7:0]        out_data,
  output logic              out_done,
  output logic [RSP_AW:0]   out_len,
  output logic              poll_on,
  output logic              shutdown_req
);
  localparam int DEPTH = 1 << RSP_AW;
  localparam int DMAX  = DEPTH - 2;
  localparam int PCW   = $clog2(POLL_DIV + 1);

  localparam logic [2:0] K_BUS = 3'd0, K_POLL = 3'd1, K_AP = 3'd2,
                         K_TIME = 3'd3, K_ACK = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_RX, S_WAIT, S_EMIT} st_t;

  st_t             st;
  logic [1:0]      nb;
  logic [7:0]      ptype, cmd, arg, code;
  logic [2:0]      kind, idx;
  logic            err;
  logic [RSP_AW-1:0] dlen;
  logic [31:0]     secs, tsnap;
  logic [PCW-1:0]  pcnt;
  logic            ppend;

  logic [7:0] cur_cmd, cur_arg, hdr;
  logic [2:0] hlen;
  logic       emit_last, data_wr;

  assign cur_cmd = (nb == 2'd1) ? in_data : cmd;
  assign cur_arg = (nb == 2'd2) ? in_data : (nb == 2'd3) ? arg : 8'h00;

  assign bus_poll      = (st == S_IDLE) && ppend && !in_valid;
  assign bus_req_valid = in_valid && (st == S_RX) && (ptype == 8'h00);
  assign bus_req_data  = in_data;
  assign bus_req_last  = in_last;

  assign hlen      = (kind == K_TIME) ? 3'd7 : 3'd2;
  assign emit_last = (st == S_EMIT) && (idx == hlen - 3'd1);
  assign data_wr   = (st == S_WAIT) && bus_rsp_valid && !bus_rsp_err
                     && (dlen < RSP_AW'(DMAX));

  always_comb begin
    hdr = 8'h00;
    case (kind)
      K_BUS:  hdr = (idx == 3'd1 && err) ? code : 8'h00;
      K_POLL: hdr = (idx == 3'd1) ? 8'h40 : 8'h00;
      K_AP:   hdr = (idx == 3'd0) ? 8'h01 : arg;
      K_TIME: case (idx)
                3'd0:    hdr = 8'h01;
                3'd3:    hdr = tsnap[31:24];
                3'd4:    hdr = tsnap[23:16];
                3'd5:    hdr = tsnap[15:8];
                3'd6:    hdr = tsnap[7:0];
                default: hdr = 8'h00;
              endcase
      default: hdr = (idx == 3'd0) ? 8'h01 : 8'h00;
    endcase
  end

  assign out_we   = data_wr || (st == S_EMIT);
  assign out_addr = (st == S_EMIT) ? RSP_AW'(idx) : dlen + RSP_AW'(2);
  assign out_data = (st == S_EMIT) ? hdr : bus_rsp_data;
  assign out_done = emit_last;
  assign out_len  = (RSP_AW+1)'(hlen) + (RSP_AW+1)'(dlen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      secs <= SEC_INIT;
    end else if (sec_tick) begin
      secs <= secs + 32'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !poll_on) begin
      pcnt  <= '0;
      ppend <= 1'b0;
    end else begin
      if (bus_poll) ppend <= 1'b0;
      if (pcnt == PCW'(POLL_DIV - 1)) begin
        pcnt  <= '0;
        ppend <= 1'b1;
      end else begin
        pcnt <= pcnt + PCW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; nb <= '0; ptype <= '0; cmd <= '0; arg <= '0;
      code <= '0; kind <= K_ACK; idx <= '0; err <= 1'b0; dlen <= '0;
      tsnap <= '0; poll_on <= 1'b0; shutdown_req <= 1'b0;
    end else begin
      shutdown_req <= 1'b0;
      case (st)
        S_IDLE: begin
          dlen <= '0; idx <= '0; err <= 1'b0;
          if (in_valid) begin
            ptype <= in_data;
            nb    <= 2'd1;
            if (!in_last) st <= S_RX;
          end else if (ppend) begin
            kind <= K_POLL;
            st   <= S_WAIT;
          end
        end
        S_RX: if (in_valid) begin
          if (nb == 2'd1) cmd <= in_data;
          if (nb == 2'd2) arg <= in_data;
          if (nb != 2'd3) nb <= nb + 2'd1;
          if (in_last) begin
            st <= S_IDLE;
            if (ptype == 8'h00) begin
              kind <= K_BUS; st <= S_WAIT;
            end else if (ptype == 8'h01) begin
              case (cur_cmd)
                8'h01: begin
                  poll_on <= (cur_arg != 8'h00);
                  arg <= cur_arg; kind <= K_AP; st <= S_EMIT;
                end
                8'h03, 8'h09: begin
                  tsnap <= secs; kind <= K_TIME; st <= S_EMIT;
                end
                8'h13, 8'h14, 8'h19, 8'h21: begin
                  kind <= K_ACK; st <= S_EMIT;
                end
                8'h0A: begin
                  kind <= K_ACK; st <= S_EMIT; shutdown_req <= 1'b1;
                end
                default: st <= S_IDLE;
              endcase
            end
          end
        end
        S_WAIT: if (bus_rsp_valid) begin
          if (bus_rsp_err) begin
            err  <= 1'b1;
            code <= bus_rsp_data;
            st   <= (kind == K_POLL) ? S_IDLE : S_EMIT;
          end else begin
            if (data_wr) dlen <= dlen + RSP_AW'(1);
            if (bus_rsp_last) st <= S_EMIT;
          end
        end
        default: begin
          idx <= idx + 3'd1;
          if (emit_last) st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/cmd_responder_chk.sv
module cmd_responder_chk #(
  parameter int RSP_AW = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_last,
  input logic            bus_poll,
  input logic            out_we,
  input logic            out_done,
  input logic [RSP_AW:0] out_len,
  input logic            poll_on,
  input logic            shutdown_req
);
  localparam int DEPTH = 1 << RSP_AW;

  // R7
  shut_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);

  // R7
  shut_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown_req) |-> $past(in_valid && in_last));

  // R3
  poll_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_poll |-> poll_on);

  // R3
  poll_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_poll |=> !bus_poll);

  // R2
  ap_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(poll_on) |-> $past(in_valid && in_last));

  // R11
  done_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> out_we);

  // R11
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (out_len >= (RSP_AW+1)'(2) && out_len <= (RSP_AW+1)'(DEPTH)));
endmodule

bind cmd_responder cmd_responder_chk #(.RSP_AW(RSP_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .bus_poll(bus_poll), .out_we(out_we), .out_done(out_done),
  .out_len(out_len), .poll_on(poll_on), .shutdown_req(shutdown_req)
);

// File: tb/tb_cmd_responder.sv
module tb_cmd_responder;
  localparam int          AW   = 3;
  localparam int          PDIV = 40;
  localparam logic [31:0] SEC0 = 32'd2082844800;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, sec_tick = 0;
  logic [7:0] in_data = 0;
  logic bus_rsp_valid = 0, bus_rsp_last = 0, bus_rsp_err = 0;
  logic [7:0] bus_rsp_data = 0;
  logic bus_req_valid, bus_req_last, bus_poll, out_we, out_done, poll_on, shutdown_req;
  logic [7:0] bus_req_data, out_data;
  logic [AW-1:0] out_addr;
  logic [AW:0] out_len;

  cmd_responder #(.RSP_AW(AW), .POLL_DIV(PDIV), .SEC_INIT(SEC0)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .sec_tick(sec_tick), .bus_req_valid(bus_req_valid),
    .bus_req_data(bus_req_data), .bus_req_last(bus_req_last), .bus_poll(bus_poll),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data),
    .bus_rsp_last(bus_rsp_last), .bus_rsp_err(bus_rsp_err), .out_we(out_we),
    .out_addr(out_addr), .out_data(out_data), .out_done(out_done),
    .out_len(out_len), .poll_on(poll_on), .shutdown_req(shutdown_req));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int done_cnt = 0, shut_cnt = 0, poll_cnt = 0, wcnt = 0;
  int poll_cyc[$];
  logic [63:0] exq[$];
  int exl[$];
  logic [8:0] fwdq[$];
  logic [7:0] mem [8];
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] b8(input logic [7:0] a0 = 0, a1 = 0, a2 = 0, a3 = 0,
                                      a4 = 0, a5 = 0, a6 = 0, a7 = 0);
    return {a7, a6, a5, a4, a3, a2, a1, a0};
  endfunction

  always @(posedge clk) cyc++;

  always @(negedge clk) if (rst_n) begin
    if (out_we) begin mem[out_addr] = out_data; wcnt++; end
    if (shutdown_req) shut_cnt++;
    if (bus_poll) begin poll_cnt++; poll_cyc.push_back(cyc); end
    if (bus_req_valid) fwdq.push_back({bus_req_last, bus_req_data});
    if (out_done) begin
      done_cnt++;
      if (exq.size() == 0) chk(0, "R9 unexpected reply", out_len, 0);
      else begin
        logic [63:0] e; int l;
        e = exq.pop_front(); l = exl.pop_front();
        chk(out_len == l, "R11 reply length", out_len, l);
        chk(wcnt == l, "R11 write count", wcnt, l);
        for (int i = 0; i < l; i++)
          chk(mem[i] == e[8*i +: 8], "R2-R8 reply byte", mem[i], e[8*i +: 8]);
      end
      wcnt = 0;
    end
  end

  task automatic expect_pkt(input logic [63:0] e, input int l);
    exq.push_back(e); exl.push_back(l);
  endtask

  task automatic send_pkt(input logic [63:0] p, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_data = p[8*i +: 8]; in_last = (i == n - 1);
    end
    @(posedge clk); #1;
    in_valid = 0; in_last = 0;
  endtask

  task automatic bus_reply(input logic [63:0] p, input int n, input bit e);
    for (int i = 0; i < n; i++) begin
      bus_rsp_valid = 1; bus_rsp_data = p[8*i +: 8];
      bus_rsp_last = (i == n - 1); bus_rsp_err = e;
      @(posedge clk); #1;
    end
    bus_rsp_valid = 0; bus_rsp_last = 0; bus_rsp_err = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_poll();
    int p0;
    p0 = poll_cnt;
    while (poll_cnt == p0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    int d0, s0, p0;
    logic [31:0] t;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    chk(!out_we && !out_done, "R1 no write after reset", {out_we, out_done}, 0);
    chk(!shutdown_req && !bus_poll && !bus_req_valid, "R1 quiet pulses",
        {shutdown_req, bus_poll, bus_req_valid}, 0);
    chk(poll_on == 0, "R1 autopoll off", poll_on, 0);
    idle(1);

    // R4 R5 reset seconds
    t = SEC0;
    expect_pkt(b8(1, 0, 0, t[31:24], t[23:16], t[15:8], t[7:0]), 7);
    send_pkt(b8(1, 8'h03), 2); idle(12);
    // R5 counting, R4 set time
    for (int i = 0; i < 5; i++) begin sec_tick = 1; @(posedge clk); #1; sec_tick = 0; end
    t = SEC0 + 5;
    expect_pkt(b8(1, 0, 0, t[31:24], t[23:16], t[15:8], t[7:0]), 7);
    send_pkt(b8(1, 8'h09, 8'hAA, 8'hBB), 4); idle(12);

    // R6
    expect_pkt(b8(1, 0), 2); send_pkt(b8(1, 8'h13), 2); idle(6);
    expect_pkt(b8(1, 0), 2); send_pkt(b8(1, 8'h19), 2); idle(6);
    expect_pkt(b8(1, 0), 2); send_pkt(b8(1, 8'h14, 8'h05), 3); idle(6);
    expect_pkt(b8(1, 0), 2); send_pkt(b8(1, 8'h21), 2); idle(6);

    // R7
    s0 = shut_cnt;
    expect_pkt(b8(1, 0), 2); send_pkt(b8(1, 8'h0A), 2); idle(6);
    chk(shut_cnt == s0 + 1, "R7 shutdown pulse count", shut_cnt, s0 + 1);

    // R9
    d0 = done_cnt;
    send_pkt(b8(1, 8'h55), 2); idle(6);
    send_pkt(b8(3, 8'h01), 2); idle(6);
    send_pkt(b8(1), 1); idle(6);
    send_pkt(b8(1, 8'h07, 8'h01), 3); idle(6);
    chk(done_cnt == d0, "R9 silent packets", done_cnt, d0);

    // R8 success
    fwdq.delete();
    send_pkt(b8(0, 8'h2C, 8'h11), 3);
    chk(fwdq.size() == 2, "R8 forwarded count", fwdq.size(), 2);
    if (fwdq.size() == 2) begin
      chk(fwdq[0] == 9'h02C, "R8 forwarded byte0", fwdq[0], 9'h02C);
      chk(fwdq[1] == 9'h111, "R8 forwarded last", fwdq[1], 9'h111);
    end
    expect_pkt(b8(0, 0, 8'h5A, 8'h6B, 8'h7C), 5);
    bus_reply(b8(8'h5A, 8'h6B, 8'h7C), 3, 0); idle(6);

    // R8 error
    send_pkt(b8(0, 8'h3C), 2);
    expect_pkt(b8(0, 8'h02), 2);
    bus_reply(b8(8'h02), 1, 1); idle(6);

    // R10 ignored while pending
    s0 = shut_cnt;
    send_pkt(b8(0, 8'h40), 2);
    send_pkt(b8(1, 8'h0A), 2);
    send_pkt(b8(1, 8'h01, 8'h01), 3);
    expect_pkt(b8(0, 0, 8'h99), 3);
    bus_reply(b8(8'h99), 1, 0); idle(6);
    chk(shut_cnt == s0, "R10 no shutdown from ignored bytes", shut_cnt, s0);
    chk(poll_on == 0, "R10 autopoll untouched", poll_on, 0);

    // R11 saturation
    send_pkt(b8(0, 8'h50), 2);
    expect_pkt(b8(0, 0, 1, 2, 3, 4, 5, 6), 8);
    bus_reply(b8(1, 2, 3, 4, 5, 6, 7, 8), 8, 0); idle(6);

    // R2
    expect_pkt(b8(1, 0), 2); send_pkt(b8(1, 8'h01), 2); idle(6);
    chk(poll_on == 0, "R2 missing argument", poll_on, 0);
    expect_pkt(b8(1, 8'h03), 2); send_pkt(b8(1, 8'h01, 8'h03), 3); idle(6);
    chk(poll_on == 1, "R2 autopoll on", poll_on, 1);

    // R3 poll with data, then error poll
    poll_cyc.delete();
    wait_poll();
    expect_pkt(b8(0, 8'h40, 8'hC1, 8'hC2), 4);
    bus_reply(b8(8'hC1, 8'hC2), 2, 0);
    d0 = done_cnt + 1;
    wait_poll();
    if (poll_cyc.size() == 2)
      chk(poll_cyc[1] - poll_cyc[0] == PDIV, "R3 poll spacing",
          poll_cyc[1] - poll_cyc[0], PDIV);
    else chk(0, "R3 poll spacing count", poll_cyc.size(), 2);
    bus_reply(b8(8'h03), 1, 1); idle(6);
    chk(done_cnt == d0, "R3 failed poll silent", done_cnt, d0);

    // R3 disable
    expect_pkt(b8(1, 0), 2); send_pkt(b8(1, 8'h01, 8'h00), 3); idle(6);
    chk(poll_on == 0, "R2 autopoll off", poll_on, 0);
    p0 = poll_cnt;
    idle(3 * PDIV);
    chk(poll_cnt == p0, "R3 no poll when off", poll_cnt, p0);

    chk(exq.size() == 0, "R2-R8 replies outstanding", exq.size(), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule